// File: doc/BRIEF.md
# Parallel NOR Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide parallel NOR flash bus. It takes one request at a time through a valid/ready handshake. A request is either a single-byte program or a whole-device erase. The block turns the request into the unlock-prefixed series of command writes the flash expects, with each write strobe timed in clock cycles. It then reads the status bit 7 back from the flash until the operation is seen to finish or a poll budget runs out.

Each request ends with a one-cycle `done` pulse. The `error` output is high in that same cycle when the request failed. A request fails when the poll budget expires. A program request can also fail early: when the caller supplies the current contents of the byte and the new value would need a bit to go from 0 to 1, the block rejects the request at once and touches no bus signal. The data bus is split into an output, an output enable and an input, so that the three-state pad can sit at chip level.

Top module: `nor_prog_ctrl`

## Requirements
- R1: A program request (`req_op`=0) issues exactly four bus writes, as address/data pairs in this order: 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0, then the request address with the request data.
- R2: An erase request (`req_op`=1) issues exactly six bus writes in this order: 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, 0x555/0x10.
- R3: During every write, `flash_we_n` stays low for exactly WE_LOW_CYC cycles. Address and write data do not change while it is low. Data is still driven in the cycle after it rises. At least WE_HIGH_CYC cycles pass with `flash_we_n` high between two writes. `flash_we_n` and `flash_oe_n` are never low together.
- R4: Status reads hold `flash_oe_n` low for OE_CYC cycles, and `flash_dq_oe` is 0 throughout. Reads use the request address after a program and address 0 after an erase.
- R5: A program finishes with `done`=1 and `error`=0 at the first status read whose bit 7 equals bit 7 of the request data.
- R6: An erase finishes with `done`=1 and `error`=0 at the first status read whose bit 7 is 1.
- R7: If POLL_LIMIT status reads in a row do not show completion, the block raises `done` with `error`=1 after exactly POLL_LIMIT reads and returns to idle.
- R8: When `req_chk`=1 on a program request and some bit is 1 in `req_data` but 0 in `req_pre`, `done` and `error` are raised and no bus cycle is made. When every set bit of `req_data` is also set in `req_pre`, the program goes ahead.
- R9: `req_ready` is 0 from the cycle after a request is accepted until `done`. Requests presented during that time are ignored and cause no bus activity.
- R10: After reset, and after a reset applied in the middle of an operation, `flash_ce_n`, `flash_we_n` and `flash_oe_n` are 1, `flash_dq_oe` is 0, `req_ready` is 1 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_op | input | 1 | 0 = program byte, 1 = erase whole device |
| req_addr | input | AW | Byte address to program |
| req_data | input | 8 | Byte to program |
| req_chk | input | 1 | Enable the 0-to-1 check against `req_pre` |
| req_pre | input | 8 | Current contents of the target byte |
| done | output | 1 | One-cycle end-of-request pulse |
| error | output | 1 | Request failed; valid with `done` |
| flash_ce_n | output | 1 | Chip enable, low during a bus cycle |
| flash_we_n | output | 1 | Write strobe |
| flash_oe_n | output | 1 | Read strobe |
| flash_addr | output | AW | Flash address |
| flash_dq_out | output | 8 | Write data toward the flash |
| flash_dq_oe | output | 1 | Drive enable for `flash_dq_out` |
| flash_dq_in | input | 8 | Read data from the flash |

## Verification
A wrong step index in the sequencer shows up as a wrong address/data pair on the bus at that write. It is caught as soon as `flash_we_n` rises. A wrong state in the bus engine shows up within one cycle as a strobe of the wrong length, overlapping strobes, or a driven data bus during a read. A wrong poll counter or completion compare changes the number of reads or the `error` value seen at the `done` pulse. The bench counts reads against a flash model that stays busy for a set number of reads, so an off-by-one in the budget is seen at the end of that request.

// File: rtl/nor_flash_pkg.sv
// Package: types and command codes shared by the NOR flash sequencer.
// Assumes an address of at least 11 bits, so the unlock addresses fit.
package nor_flash_pkg;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_e;

    localparam logic [10:0] UNLK_A1 = 11'h555;
    localparam logic [10:0] UNLK_A2 = 11'h2AA;
    localparam logic [7:0]  UNLK_D1 = 8'hAA;
    localparam logic [7:0]  UNLK_D2 = 8'h55;
    localparam logic [7:0]  CMD_PROG   = 8'hA0;
    localparam logic [7:0]  CMD_ERSETUP = 8'h80;
    localparam logic [7:0]  CMD_CHIPER = 8'h10;

    localparam int PROG_STEPS  = 4;
    localparam int ERASE_STEPS = 6;

endpackage

// File: rtl/nor_cmd_seq.sv
// nor_cmd_seq: combinational lookup of the address/data pair for one step
// of a command series. Assumes idx stays below the step count of the op.
module nor_cmd_seq
    import nor_flash_pkg::*;
#(
    parameter int AW = 17
) (
    input  op_e           op,
    input  logic [2:0]    idx,
    input  logic [AW-1:0] tgt_addr,
    input  logic [7:0]    tgt_data,
    output logic [AW-1:0] step_addr,
    output logic [7:0]    step_data,
    output logic          step_last
);
    localparam logic [AW-1:0] A1 = AW'(UNLK_A1);
    localparam logic [AW-1:0] A2 = AW'(UNLK_A2);

    // Select the pair for the current step; unlock pairs are shared.
    always_comb begin
        step_addr = A1;
        step_data = UNLK_D1;
        if (op == OP_PROG) begin
            step_last = (idx == 3'(PROG_STEPS - 1));
            case (idx)
                3'd1:    begin step_addr = A2;       step_data = UNLK_D2;  end
                3'd2:    begin step_addr = A1;       step_data = CMD_PROG; end
                3'd3:    begin step_addr = tgt_addr; step_data = tgt_data; end
                default: begin step_addr = A1;       step_data = UNLK_D1;  end
            endcase
        end else begin
            step_last = (idx == 3'(ERASE_STEPS - 1));
            case (idx)
                3'd1, 3'd4: begin step_addr = A2; step_data = UNLK_D2;     end
                3'd2:       begin step_addr = A1; step_data = CMD_ERSETUP; end
                3'd5:       begin step_addr = A1; step_data = CMD_CHIPER;  end
                default:    begin step_addr = A1; step_data = UNLK_D1;     end
            endcase
        end
    end
endmodule

// File: rtl/nor_bus_phy.sv
// nor_bus_phy: runs one flash bus cycle (write or status read) per start.
// Phases: setup (CE low, address out), strobe (WE or OE low), recovery
// (strobes high, write data still driven). fin pulses in the last cycle.
// Assumes start is only raised while idle is high.
module nor_bus_phy #(
    parameter int AW          = 17,
    parameter int WE_LOW_CYC  = 3,
    parameter int WE_HIGH_CYC = 2,
    parameter int OE_CYC      = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_wr,
    input  logic [AW-1:0] addr_in,
    input  logic [7:0]    data_in,
    output logic          idle,
    output logic          fin,
    output logic          rd_bit7,
    output logic          ce_n,
    output logic          we_n,
    output logic          oe_n,
    output logic [AW-1:0] addr,
    output logic [7:0]    dq_out,
    output logic          dq_oe,
    input  logic [7:0]    dq_in
);
    localparam int MAXC = (WE_LOW_CYC > OE_CYC ? WE_LOW_CYC : OE_CYC) > WE_HIGH_CYC
                        ? (WE_LOW_CYC > OE_CYC ? WE_LOW_CYC : OE_CYC) : WE_HIGH_CYC;
    localparam int CW = $clog2(MAXC + 1);

    typedef enum logic [1:0] {P_IDLE, P_SETUP, P_STROBE, P_RECOV} pst_e;

    pst_e          st;
    logic [CW-1:0] cnt;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;
    logic          wr_q;
    logic [CW-1:0] strobe_end;

    assign strobe_end = wr_q ? CW'(WE_LOW_CYC - 1) : CW'(OE_CYC - 1);

    // Phase sequencer with cycle counter and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= P_IDLE;
            cnt     <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            wr_q    <= 1'b0;
            rd_bit7 <= 1'b0;
        end else begin
            case (st)
                P_IDLE: if (start) begin
                    addr_q <= addr_in;
                    data_q <= data_in;
                    wr_q   <= is_wr;
                    cnt    <= '0;
                    st     <= P_SETUP;
                end
                P_SETUP: st <= P_STROBE;
                P_STROBE: begin
                    if (cnt == strobe_end) begin
                        cnt <= '0;
                        st  <= P_RECOV;
                        if (!wr_q) rd_bit7 <= dq_in[7];
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                P_RECOV: begin
                    if (cnt == CW'(WE_HIGH_CYC - 1)) begin
                        cnt <= '0;
                        st  <= P_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= P_IDLE;
            endcase
        end
    end

    // Bus pins decoded from the phase.
    always_comb begin
        idle   = (st == P_IDLE);
        fin    = (st == P_RECOV) && (cnt == CW'(WE_HIGH_CYC - 1));
        ce_n   = (st == P_IDLE);
        we_n   = !((st == P_STROBE) && wr_q);
        oe_n   = !((st == P_STROBE) && !wr_q);
        dq_oe  = wr_q && (st != P_IDLE);
        addr   = addr_q;
        dq_out = data_q;
    end

    assert_no_strobe_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !oe_n));

    assert_wr_pins_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> ($stable(addr) && $stable(dq_out)));

    assert_data_after_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> dq_oe);

    assert_bus_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !dq_oe);
endmodule

// File: rtl/nor_prog_ctrl.sv
// nor_prog_ctrl: top of the flash program/erase sequencer. Accepts one
// request, optionally rejects a program that needs a 0-to-1 change, issues
// the command writes, then polls status bit 7 up to POLL_LIMIT times.
// Assumes AW >= 11 and POLL_LIMIT >= 1.
module nor_prog_ctrl
    import nor_flash_pkg::*;
#(
    parameter int AW          = 17,
    parameter int WE_LOW_CYC  = 3,
    parameter int WE_HIGH_CYC = 2,
    parameter int OE_CYC      = 2,
    parameter int POLL_LIMIT  = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    input  logic          req_chk,
    input  logic [7:0]    req_pre,
    output logic          done,
    output logic          error,
    output logic          flash_ce_n,
    output logic          flash_we_n,
    output logic          flash_oe_n,
    output logic [AW-1:0] flash_addr,
    output logic [7:0]    flash_dq_out,
    output logic          flash_dq_oe,
    input  logic [7:0]    flash_dq_in
);
    localparam int PW = $clog2(POLL_LIMIT + 1);

    typedef enum logic [1:0] {C_IDLE, C_CMD, C_POLL, C_DONE} cst_e;

    cst_e          st;
    op_e           op_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;
    logic [2:0]    idx;
    logic [PW-1:0] polls;
    logic          err_q;

    logic [AW-1:0] seq_addr;
    logic [7:0]    seq_data;
    logic          seq_last;
    logic          phy_idle, phy_fin, phy_bit7, phy_start;
    logic [AW-1:0] phy_addr;
    logic          expect_bit7;
    logic          raise_bit;

    nor_cmd_seq #(.AW(AW)) seq_i (
        .op(op_q), .idx(idx), .tgt_addr(addr_q), .tgt_data(data_q),
        .step_addr(seq_addr), .step_data(seq_data), .step_last(seq_last)
    );

    // Drive the bus engine: command writes, then reads at the poll address.
    always_comb begin
        phy_start   = ((st == C_CMD) || (st == C_POLL)) && phy_idle;
        phy_addr    = (st == C_CMD) ? seq_addr : ((op_q == OP_ERASE) ? '0 : addr_q);
        expect_bit7 = (op_q == OP_ERASE) ? 1'b1 : data_q[7];
        raise_bit   = req_chk && (req_op == 1'b0) && ((req_data & ~req_pre) != 8'h00);
    end

    nor_bus_phy #(
        .AW(AW), .WE_LOW_CYC(WE_LOW_CYC), .WE_HIGH_CYC(WE_HIGH_CYC), .OE_CYC(OE_CYC)
    ) phy_i (
        .clk(clk), .rst_n(rst_n), .start(phy_start), .is_wr(st == C_CMD),
        .addr_in(phy_addr), .data_in(seq_data), .idle(phy_idle), .fin(phy_fin),
        .rd_bit7(phy_bit7), .ce_n(flash_ce_n), .we_n(flash_we_n), .oe_n(flash_oe_n),
        .addr(flash_addr), .dq_out(flash_dq_out), .dq_oe(flash_dq_oe), .dq_in(flash_dq_in)
    );

    // Request state machine: accept, command, poll, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= C_IDLE;
            op_q   <= OP_PROG;
            addr_q <= '0;
            data_q <= '0;
            idx    <= '0;
            polls  <= '0;
            err_q  <= 1'b0;
        end else begin
            case (st)
                C_IDLE: if (req_valid) begin
                    op_q   <= op_e'(req_op);
                    addr_q <= req_addr;
                    data_q <= req_data;
                    idx    <= '0;
                    polls  <= '0;
                    err_q  <= raise_bit;
                    st     <= raise_bit ? C_DONE : C_CMD;
                end
                C_CMD: if (phy_fin) begin
                    if (seq_last) st <= C_POLL;
                    else          idx <= idx + 1'b1;
                end
                C_POLL: if (phy_fin) begin
                    if (phy_bit7 == expect_bit7) begin
                        err_q <= 1'b0;
                        st    <= C_DONE;
                    end else if (polls == PW'(POLL_LIMIT - 1)) begin
                        err_q <= 1'b1;
                        st    <= C_DONE;
                    end else begin
                        polls <= polls + 1'b1;
                    end
                end
                default: st <= C_IDLE;
            endcase
        end
    end

    // Handshake and result outputs.
    always_comb begin
        req_ready = (st == C_IDLE);
        done      = (st == C_DONE);
        error     = (st == C_DONE) && err_q;
    end

    assert_idle_bus_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (flash_ce_n && flash_we_n && flash_oe_n && !flash_dq_oe));

    assert_fast_done_is_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(req_ready)) |-> error);

    assert_ready_drops_on_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |-> $past(req_valid));

    assert_poll_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == C_POLL) |-> (polls < PW'(POLL_LIMIT)));
endmodule

// File: tb/nor_prog_ctrl_tb.sv
module nor_prog_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 17;
    localparam int WLO  = 3;
    localparam int WHI  = 2;
    localparam int OEC  = 2;
    localparam int PLIM = 8;
    localparam int NV   = 7;

    // Vectors: op, addr, data, chk, pre, busy reads
    localparam logic        V_OP   [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
    localparam logic [16:0] V_ADDR [NV] = '{17'h01234, 17'h1FFFF, 17'h00777, 17'h00100,
                                            17'h0ABCD, 17'h00042, 17'h00000};
    localparam logic [7:0]  V_DATA [NV] = '{8'h5A, 8'hA5, 8'h00, 8'h0F, 8'h80, 8'h14, 8'h00};
    localparam logic        V_CHK  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam logic [7:0]  V_PRE  [NV] = '{8'h00, 8'hFF, 8'h00, 8'hF0, 8'h00, 8'h3C, 8'h00};
    localparam int          V_BUSY [NV] = '{2, 0, 5, 0, 8, 7, 8};

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_op = 1'b0, req_chk = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0] req_data = '0, req_pre = '0;
    logic req_ready, done, error, ce_n, we_n, oe_n, dq_oe;
    logic [AW-1:0] faddr;
    logic [7:0] dq_out, dq_in;

    int n_chk = 0, n_fail = 0;

    // Flash model state
    int  busy_left = 0;
    logic tgt_bit = 1'b0;
    logic [AW-1:0] exp_poll_addr = '0;
    int  wr_n = 0, rd_n = 0, we_min = 999, we_max = 0, we_run = 0, hi_run = 0;
    bit  rd_addr_bad = 0, oe_dq_bad = 0, gap_bad = 0;
    logic prev_we = 1'b1, prev_oe = 1'b1;
    logic [AW-1:0] wa [8];
    logic [7:0]    wd [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign dq_in = {(busy_left > 0) ? ~tgt_bit : tgt_bit, 7'h00};

    nor_prog_ctrl #(.AW(AW), .WE_LOW_CYC(WLO), .WE_HIGH_CYC(WHI), .OE_CYC(OEC),
                    .POLL_LIMIT(PLIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_chk(req_chk),
        .req_pre(req_pre), .done(done), .error(error), .flash_ce_n(ce_n),
        .flash_we_n(we_n), .flash_oe_n(oe_n), .flash_addr(faddr), .flash_dq_out(dq_out),
        .flash_dq_oe(dq_oe), .flash_dq_in(dq_in)
    );

    // Bus monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (!we_n) begin
            we_run = we_run + 1;
            if (prev_we && wr_n > 0 && hi_run < WHI) gap_bad = 1;
        end else begin
            hi_run = hi_run + 1;
        end
        if (prev_we == 1'b0 && we_n == 1'b1) begin
            if (wr_n < 8) begin wa[wr_n] = faddr; wd[wr_n] = dq_out; end
            if (!dq_oe) gap_bad = 1;
            wr_n = wr_n + 1;
            if (we_run < we_min) we_min = we_run;
            if (we_run > we_max) we_max = we_run;
            we_run = 0;
            hi_run = 1;
        end
        if (!oe_n) begin
            if (faddr != exp_poll_addr) rd_addr_bad = 1;
            if (dq_oe) oe_dq_bad = 1;
        end
        if (prev_oe == 1'b0 && oe_n == 1'b1) begin
            rd_n = rd_n + 1;
            if (busy_left > 0) busy_left = busy_left - 1;
        end
        prev_we = we_n;
        prev_oe = oe_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_wa(input logic op, input int i, input logic [AW-1:0] a);
        if (op == 1'b0) return (i == 3) ? a : ((i == 1) ? AW'(17'h2AA) : AW'(17'h555));
        return (i == 1 || i == 4) ? AW'(17'h2AA) : AW'(17'h555);
    endfunction

    function automatic logic [7:0] exp_wd(input logic op, input int i, input logic [7:0] d);
        if (op == 1'b0) begin
            case (i) 0: return 8'hAA; 1: return 8'h55; 2: return 8'hA0; default: return d; endcase
        end
        case (i)
            0, 3: return 8'hAA;
            1, 4: return 8'h55;
            2: return 8'h80;
            default: return 8'h10;
        endcase
    endfunction

    bit ready_bad;

    task automatic run_op(input logic op, input logic [AW-1:0] a, input logic [7:0] d,
                          input logic c, input logic [7:0] p, input int busy, input bit inject,
                          output bit got_done, output bit got_err);
        wr_n = 0; rd_n = 0; we_min = 999; we_max = 0; we_run = 0; hi_run = 0;
        rd_addr_bad = 0; oe_dq_bad = 0; gap_bad = 0; ready_bad = 0;
        busy_left = busy;
        tgt_bit = op ? 1'b1 : d[7];
        exp_poll_addr = op ? '0 : a;
        got_done = 0; got_err = 0;
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_chk = c; req_pre = p;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 0; cyc < 5000; cyc++) begin
            if (done) begin got_done = 1; got_err = error; break; end
            if (req_ready) ready_bad = 1;
            if (inject) begin
                req_valid = (cyc >= 3 && cyc < 20);
                req_op = 1'b1; req_chk = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        if (!got_done) chk(0, "watchdog", 0, 1);
    endtask

    initial begin
        bit gd, ge;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(ce_n && we_n && oe_n && !dq_oe && req_ready && !done, "R10 reset",
            {ce_n, we_n, oe_n, dq_oe, req_ready, done}, 6'b111010);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            bit rej, exp_err;
            int exp_wr, exp_rd;
            bit seq_ok;
            rej = V_CHK[v] && !V_OP[v] && ((V_DATA[v] & ~V_PRE[v]) != 0);
            exp_err = rej || (V_BUSY[v] >= PLIM);
            exp_wr = rej ? 0 : (V_OP[v] ? 6 : 4);
            exp_rd = rej ? 0 : ((V_BUSY[v] + 1 < PLIM) ? V_BUSY[v] + 1 : PLIM);
            run_op(V_OP[v], V_ADDR[v], V_DATA[v], V_CHK[v], V_PRE[v], V_BUSY[v], 0, gd, ge);
            repeat (4) @(negedge clk);
            // R1 / R2 write count and series
            chk(wr_n == exp_wr, V_OP[v] ? "R2 write count" : "R1 write count", wr_n, exp_wr);
            seq_ok = 1;
            for (int i = 0; i < exp_wr && i < 8; i++)
                if (wa[i] != exp_wa(V_OP[v], i, V_ADDR[v]) || wd[i] != exp_wd(V_OP[v], i, V_DATA[v]))
                    seq_ok = 0;
            chk(seq_ok, V_OP[v] ? "R2 write series" : "R1 write series", v, v);
            if (exp_wr > 0) begin
                chk(we_min == WLO && we_max == WLO && !gap_bad, "R3 strobe timing", we_max, WLO);
                chk(!rd_addr_bad && !oe_dq_bad, "R4 poll address/bus release", rd_addr_bad, 0);
            end
            // R5 R6 R7 R8 result and read count
            chk(rd_n == exp_rd, exp_err ? "R7 read count" : "R5/R6 read count", rd_n, exp_rd);
            chk(ge == exp_err, rej ? "R8 reject" : (V_OP[v] ? "R6 erase result" : "R5 program result"),
                ge, exp_err);
            chk(!ready_bad, "R9 ready low while busy", ready_bad, 0);
        end

        // R9: request presented while busy is ignored
        run_op(1'b0, 17'h00321, 8'h33, 1'b0, 8'h00, 1, 1, gd, ge);
        repeat (12) @(negedge clk);
        chk(wr_n == 4 && !ge, "R9 ignored request", wr_n, 4);
        chk(ce_n && req_ready, "R9 no follow-on op", ce_n, 1);

        // R10: reset in the middle of a write
        req_valid = 1'b1; req_op = 1'b1; req_chk = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(ce_n && we_n && oe_n && !dq_oe && req_ready && !done, "R10 mid-op reset",
            {ce_n, we_n, oe_n, dq_oe, req_ready, done}, 6'b111010);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(ce_n && !done, "R10 idle after reset", ce_n, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule